// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block connects a fixed set of on-chip peripheral signals to a bank of general-purpose pins. Peripherals are visited in a fixed priority order. Each enabled one is handed the lowest-numbered pins that are still free. A pin is not free if the skip mask reserves it or if an earlier peripheral already took it. Two peripherals are exceptions and always sit on fixed pins: the UART on pins 4/5 and the CAN controller on pins 6/7. A pin that no peripheral claims keeps plain GPIO behaviour and is driven from the GPIO output and output-enable vectors.

The walk over peripherals is combinational and runs from the enable vector and the skip mask. Its result is latched into a pin map on every clock. The output and input multiplexers read that latched map, so the long allocation chain never sits in the pad data path. A global crossbar-enable bit is registered together with the map. While it is clear, every pin behaves as GPIO and every peripheral input reads 1.

The signal index order is fixed. Index 0 is uart_tx and 1 is uart_rx. Index 2 is can_tx and 3 is can_rx. Indices 4 to 7 are spi sck, miso, mosi and nss. Index 8 is i2c_sda and 9 is i2c_scl. Indices 10 and up are pwm channels 0 to NUM_PWM-1. The resource enable bits are ordered the same way: 0 UART, 1 CAN, 2 SPI, 3 I2C, 4 and up one bit per PWM channel.

Top module: `periph_xbar`

## Requirements
- R1: If resource bit 0 (UART) was enabled at the last edge, pin 4 carries signal 0 and pin 5 carries signal 1, whatever the skip mask holds.
- R2: If resource bit 1 (CAN) was enabled, pin 6 carries signal 2 and pin 7 carries signal 3, and neither pin is handed to any other signal.
- R3: Walked signals (index 4 and up) of enabled resources are placed in ascending index order. Each takes the lowest-numbered pin that is still free, so the signals of one resource land on consecutive free pins.
- R4: A pin with its skip bit set never receives a walked signal. It stays GPIO unless it is a fixed UART or CAN pin whose owner is enabled.
- R5: A pin given to one signal is passed over by all later signals, so each pin has at most one owner.
- R6: If free pins run out, the remaining walked signals get no pin and overflow_o reads 1 after the edge. Otherwise it reads 0.
- R7: Any pin without an owner drives gpio_out_i and gpio_oe_i for that pin.
- R8: While the registered crossbar enable is 0, all pins act as GPIO, every sig_in_o bit is 1, and overflow_o is 0.
- R9: Changes to the configuration inputs reach the pins only after the next rising clock edge. Data from peripherals and pins passes through combinationally.
- R10: A placed signal's sig_in_o follows pin_in_i of its pin. An unplaced signal reads the idle level 1; for example, UART RX reads 1.
- R11: After reset, all pins act as GPIO, sig_in_o is all ones and overflow_o is 0.
- R12: Signals of a disabled resource get no pin and do not drive any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xbar_en_i | input | 1 | Global crossbar enable |
| res_en_i | input | NUM_RES | Per-resource enable, in priority order |
| skip_i | input | NUM_PINS | Per-pin skip mask |
| gpio_out_i | input | NUM_PINS | GPIO output values |
| gpio_oe_i | input | NUM_PINS | GPIO output enables |
| pin_in_i | input | NUM_PINS | Values read from the pins |
| pin_out_o | output | NUM_PINS | Values driven to the pins |
| pin_oe_o | output | NUM_PINS | Output enables to the pins |
| sig_out_i | input | NUM_SIG | Peripheral signal output values |
| sig_oe_i | input | NUM_SIG | Peripheral signal output enables |
| sig_in_o | output | NUM_SIG | Pin values returned to peripherals |
| overflow_o | output | 1 | Some enabled signal found no free pin |

## Verification
A corrupt pin map shows up in the same cycle it is latched. A peripheral's walking-one output value appears on the wrong pin, or on no pin at all. The input it gets back no longer follows its pin. Each directed step drives a walking one on a single signal and checks that it reaches exactly the hand-computed pin. A behavioural reference model, built from a queue of free pins, is compared on every clock while enables, skip masks and data change at random. The bench also drives a configuration change just before an edge and checks that the old map stays in force until that edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned RES_UART  = 0;
  localparam int unsigned RES_CAN   = 1;
  localparam int unsigned RES_SPI   = 2;
  localparam int unsigned RES_I2C   = 3;
  localparam int unsigned RES_PWM0  = 4;
  localparam int unsigned NUM_FIXED_RES = 4;

  localparam int unsigned SIG_UART0 = 0;
  localparam int unsigned SIG_CAN0  = 2;
  localparam int unsigned SIG_SPI0  = 4;
  localparam int unsigned SIG_I2C0  = 8;
  localparam int unsigned SIG_PWM0  = 10;
  localparam int unsigned WALK_BASE = SIG_SPI0;

  localparam int unsigned UART_PIN0 = 4;
  localparam int unsigned CAN_PIN0  = 6;
  localparam int unsigned MIN_PINS  = 8;

  function automatic int unsigned res_of_sig(int unsigned s);
    if (s < SIG_CAN0)      return RES_UART;
    else if (s < SIG_SPI0) return RES_CAN;
    else if (s < SIG_I2C0) return RES_SPI;
    else if (s < SIG_PWM0) return RES_I2C;
    else                   return RES_PWM0 + (s - SIG_PWM0);
  endfunction
endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_PWM  = 3,
  localparam int unsigned NUM_SIG = SIG_PWM0 + NUM_PWM,
  localparam int unsigned NUM_RES = NUM_FIXED_RES + NUM_PWM,
  localparam int unsigned SRC_W   = $clog2(NUM_SIG + 1),
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_RES-1:0]  res_en_i,
  input  logic [NUM_PINS-1:0] skip_i,
  output logic [SRC_W-1:0]    src_o [NUM_PINS],
  output logic [PIN_W-1:0]    sig_pin_o [NUM_SIG],
  output logic [NUM_SIG-1:0]  sig_ok_o,
  output logic                ovf_o
);
  logic [NUM_PINS-1:0] taken;
  logic                found;

  always_comb begin
    taken    = skip_i;
    ovf_o    = 1'b0;
    sig_ok_o = '0;
    found    = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) src_o[p] = '0;
    for (int s = 0; s < NUM_SIG; s++) sig_pin_o[s] = '0;

    // fixed placements, independent of skip mask
    if (res_en_i[RES_UART]) begin
      for (int k = 0; k < 2; k++) begin
        taken[UART_PIN0 + k]     = 1'b1;
        src_o[UART_PIN0 + k]     = SRC_W'(SIG_UART0 + k + 1);
        sig_pin_o[SIG_UART0 + k] = PIN_W'(UART_PIN0 + k);
        sig_ok_o[SIG_UART0 + k]  = 1'b1;
      end
    end
    if (res_en_i[RES_CAN]) begin
      for (int k = 0; k < 2; k++) begin
        taken[CAN_PIN0 + k]     = 1'b1;
        src_o[CAN_PIN0 + k]     = SRC_W'(SIG_CAN0 + k + 1);
        sig_pin_o[SIG_CAN0 + k] = PIN_W'(CAN_PIN0 + k);
        sig_ok_o[SIG_CAN0 + k]  = 1'b1;
      end
    end

    // priority walk: each signal takes lowest free pin
    for (int s = WALK_BASE; s < NUM_SIG; s++) begin
      if (res_en_i[res_of_sig(s)]) begin
        found = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!found && !taken[p]) begin
            taken[p]     = 1'b1;
            src_o[p]     = SRC_W'(s + 1);
            sig_pin_o[s] = PIN_W'(p);
            sig_ok_o[s]  = 1'b1;
            found        = 1'b1;
          end
        end
        if (!found) ovf_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_map_reg.sv
module xbar_map_reg
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_PWM  = 3,
  localparam int unsigned NUM_SIG = SIG_PWM0 + NUM_PWM,
  localparam int unsigned SRC_W   = $clog2(NUM_SIG + 1),
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SRC_W-1:0]   src_i [NUM_PINS],
  input  logic [PIN_W-1:0]   sig_pin_i [NUM_SIG],
  input  logic [NUM_SIG-1:0] sig_ok_i,
  input  logic               ovf_i,
  output logic               active_o,
  output logic [SRC_W-1:0]   src_o [NUM_PINS],
  output logic [PIN_W-1:0]   sig_pin_o [NUM_SIG],
  output logic [NUM_SIG-1:0] sig_ok_o,
  output logic               ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      ovf_o    <= 1'b0;
      sig_ok_o <= '0;
    end else begin
      active_o <= en_i;
      ovf_o    <= en_i & ovf_i;
      sig_ok_o <= sig_ok_i;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_o[p] <= '0;
      else         src_o[p] <= src_i[p];
    end
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_pin_o[s] <= '0;
      else         sig_pin_o[s] <= sig_pin_i[s];
    end
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_PWM  = 3,
  localparam int unsigned NUM_SIG = SIG_PWM0 + NUM_PWM,
  localparam int unsigned SRC_W   = $clog2(NUM_SIG + 1),
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                active_i,
  input  logic [SRC_W-1:0]    src_i [NUM_PINS],
  input  logic [PIN_W-1:0]    sig_pin_i [NUM_SIG],
  input  logic [NUM_SIG-1:0]  sig_ok_i,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  input  logic [NUM_PINS-1:0] gpio_oe_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  input  logic [NUM_SIG-1:0]  sig_out_i,
  input  logic [NUM_SIG-1:0]  sig_oe_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_SIG-1:0]  sig_in_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
    always_comb begin
      pin_out_o[p] = gpio_out_i[p];
      pin_oe_o[p]  = gpio_oe_i[p];
      if (active_i) begin
        for (int s = 0; s < NUM_SIG; s++) begin
          if (src_i[p] == SRC_W'(s + 1)) begin
            pin_out_o[p] = sig_out_i[s];
            pin_oe_o[p]  = sig_oe_i[s];
          end
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_in
    always_comb begin
      sig_in_o[s] = 1'b1; // idle level for unplaced inputs
      if (active_i && sig_ok_i[s]) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (sig_pin_i[s] == PIN_W'(p)) sig_in_o[s] = pin_in_i[p];
        end
      end
    end
  end
endmodule

// File: rtl/periph_xbar.sv
module periph_xbar
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_PWM  = 3,
  localparam int unsigned NUM_SIG = SIG_PWM0 + NUM_PWM,
  localparam int unsigned NUM_RES = NUM_FIXED_RES + NUM_PWM,
  localparam int unsigned SRC_W   = $clog2(NUM_SIG + 1),
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                xbar_en_i,
  input  logic [NUM_RES-1:0]  res_en_i,
  input  logic [NUM_PINS-1:0] skip_i,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  input  logic [NUM_PINS-1:0] gpio_oe_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_SIG-1:0]  sig_out_i,
  input  logic [NUM_SIG-1:0]  sig_oe_i,
  output logic [NUM_SIG-1:0]  sig_in_o,
  output logic                overflow_o
);
  logic [SRC_W-1:0]   src_d [NUM_PINS];
  logic [SRC_W-1:0]   src_q [NUM_PINS];
  logic [PIN_W-1:0]   sig_pin_d [NUM_SIG];
  logic [PIN_W-1:0]   sig_pin_q [NUM_SIG];
  logic [NUM_SIG-1:0] sig_ok_d, sig_ok_q;
  logic               ovf_d, active_q;

  xbar_alloc #(.NUM_PINS(NUM_PINS), .NUM_PWM(NUM_PWM)) u_alloc (
    .res_en_i  (res_en_i),
    .skip_i    (skip_i),
    .src_o     (src_d),
    .sig_pin_o (sig_pin_d),
    .sig_ok_o  (sig_ok_d),
    .ovf_o     (ovf_d)
  );

  xbar_map_reg #(.NUM_PINS(NUM_PINS), .NUM_PWM(NUM_PWM)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (xbar_en_i),
    .src_i     (src_d),
    .sig_pin_i (sig_pin_d),
    .sig_ok_i  (sig_ok_d),
    .ovf_i     (ovf_d),
    .active_o  (active_q),
    .src_o     (src_q),
    .sig_pin_o (sig_pin_q),
    .sig_ok_o  (sig_ok_q),
    .ovf_o     (overflow_o)
  );

  xbar_route #(.NUM_PINS(NUM_PINS), .NUM_PWM(NUM_PWM)) u_route (
    .active_i   (active_q),
    .src_i      (src_q),
    .sig_pin_i  (sig_pin_q),
    .sig_ok_i   (sig_ok_q),
    .gpio_out_i (gpio_out_i),
    .gpio_oe_i  (gpio_oe_i),
    .pin_in_i   (pin_in_i),
    .sig_out_i  (sig_out_i),
    .sig_oe_i   (sig_oe_i),
    .pin_out_o  (pin_out_o),
    .pin_oe_o   (pin_oe_o),
    .sig_in_o   (sig_in_o)
  );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_PWM  = 3,
  localparam int unsigned NUM_SIG = SIG_PWM0 + NUM_PWM,
  localparam int unsigned NUM_RES = NUM_FIXED_RES + NUM_PWM,
  localparam int unsigned SRC_W   = $clog2(NUM_SIG + 1),
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                xbar_en_i,
  input logic [NUM_RES-1:0]  res_en_i,
  input logic [NUM_PINS-1:0] skip_i,
  input logic [NUM_PINS-1:0] gpio_out_i,
  input logic [NUM_PINS-1:0] gpio_oe_i,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_SIG-1:0]  sig_out_i,
  input logic [NUM_SIG-1:0]  sig_in_o,
  input logic                overflow_o,
  input logic [SRC_W-1:0]    src_q [NUM_PINS],
  input logic [PIN_W-1:0]    sig_pin_q [NUM_SIG],
  input logic [NUM_SIG-1:0]  sig_ok_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_UART_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(xbar_en_i && res_en_i[RES_UART]) |->
      pin_out_o[UART_PIN0] == sig_out_i[SIG_UART0] &&
      pin_out_o[UART_PIN0+1] == sig_out_i[SIG_UART0+1]); // R1

  AST_CAN_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(xbar_en_i && res_en_i[RES_CAN]) |->
      pin_out_o[CAN_PIN0] == sig_out_i[SIG_CAN0] &&
      pin_out_o[CAN_PIN0+1] == sig_out_i[SIG_CAN0+1]); // R2

  AST_OFF_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(xbar_en_i) |->
      pin_out_o == gpio_out_i && pin_oe_o == gpio_oe_i &&
      sig_in_o == '1 && !overflow_o); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(res_en_i[NUM_RES-1:RES_SPI]) == '0 |-> !overflow_o); // R6

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_own
    AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_ok_q[s] |-> src_q[sig_pin_q[s]] == SRC_W'(s + 1)); // R5
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_skip
    if (p == UART_PIN0 || p == UART_PIN0 + 1) begin : g_u
      AST_SKIP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(skip_i[p] && !res_en_i[RES_UART]) |-> src_q[p] == '0); // R4
    end else if (p == CAN_PIN0 || p == CAN_PIN0 + 1) begin : g_c
      AST_SKIP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(skip_i[p] && !res_en_i[RES_CAN]) |-> src_q[p] == '0); // R4
    end else begin : g_w
      AST_SKIP_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(skip_i[p]) |-> src_q[p] == '0); // R4
    end
  end
endmodule

bind periph_xbar xbar_chk #(.NUM_PINS(NUM_PINS), .NUM_PWM(NUM_PWM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xbar_en_i  (xbar_en_i),
  .res_en_i   (res_en_i),
  .skip_i     (skip_i),
  .gpio_out_i (gpio_out_i),
  .gpio_oe_i  (gpio_oe_i),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .sig_out_i  (sig_out_i),
  .sig_in_o   (sig_in_o),
  .overflow_o (overflow_o),
  .src_q      (src_q),
  .sig_pin_q  (sig_pin_q),
  .sig_ok_q   (sig_ok_q)
);

// File: tb/periph_xbar_test.sv
module periph_xbar_test;
  localparam int NP = 16;
  localparam int NPWM = 3;
  localparam int NS = 10 + NPWM;
  localparam int NR = 4 + NPWM;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic xbar_en = 1'b0;
  logic [NR-1:0] res_en = '0;
  logic [NP-1:0] skip = '0, gpio_out = '0, gpio_oe = '0, pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NS-1:0] sig_out = '0, sig_oe = '0, sig_in;
  logic overflow;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  periph_xbar #(.NUM_PINS(NP), .NUM_PWM(NPWM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .xbar_en_i(xbar_en), .res_en_i(res_en),
    .skip_i(skip), .gpio_out_i(gpio_out), .gpio_oe_i(gpio_oe), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .sig_out_i(sig_out), .sig_oe_i(sig_oe),
    .sig_in_o(sig_in), .overflow_o(overflow)
  );

  // behavioural reference: free-pin queue
  int  m_src [NP];
  int  m_pin [NS];
  bit  m_act, m_ovf;

  function automatic int owner_res(int s);
    if (s < 2) return 0;
    if (s < 4) return 1;
    if (s < 8) return 2;
    if (s < 10) return 3;
    return 4 + s - 10;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    int free_q[$];
    bit excl [NP];
    bit ovf;
    for (int p = 0; p < NP; p++) m_src[p] = -1;
    for (int s = 0; s < NS; s++) m_pin[s] = -1;
    if (!rst_ni) begin
      m_act = 0; m_ovf = 0;
    end else begin
      ovf = 0;
      for (int p = 0; p < NP; p++) excl[p] = skip[p];
      if (res_en[0]) begin m_pin[0]=4; m_pin[1]=5; m_src[4]=0; m_src[5]=1; excl[4]=1; excl[5]=1; end
      if (res_en[1]) begin m_pin[2]=6; m_pin[3]=7; m_src[6]=2; m_src[7]=3; excl[6]=1; excl[7]=1; end
      free_q = {};
      for (int p = 0; p < NP; p++) if (!excl[p]) free_q.push_back(p);
      for (int s = 4; s < NS; s++) begin
        if (res_en[owner_res(s)]) begin
          if (free_q.size() > 0) begin
            m_pin[s] = free_q.pop_front();
            m_src[m_pin[s]] = s;
          end else ovf = 1;
        end
      end
      m_act = xbar_en;
      m_ovf = xbar_en && ovf;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    logic [NP-1:0] e_out, e_oe;
    logic [NS-1:0] e_in;
    for (int p = 0; p < NP; p++) begin
      if (m_act && m_src[p] >= 0) begin e_out[p] = sig_out[m_src[p]]; e_oe[p] = sig_oe[m_src[p]]; end
      else begin e_out[p] = gpio_out[p]; e_oe[p] = gpio_oe[p]; end
    end
    for (int s = 0; s < NS; s++)
      e_in[s] = (m_act && m_pin[s] >= 0) ? pin_in[m_pin[s]] : 1'b1;
    chk({tag, " pin_out"}, 64'(pin_out), 64'(e_out));
    chk({tag, " pin_oe"}, 64'(pin_oe), 64'(e_oe));
    chk({tag, " sig_in"}, 64'(sig_in), 64'(e_in));
    chk({tag, " overflow"}, 64'(overflow), 64'(m_ovf));
  endtask

  // walking one on signal s, expect it on pin p (p<0: nowhere)
  task automatic route(string tag, int s, int p);
    sig_out = NS'(1) << s;
    sig_oe  = NS'(1) << s;
    gpio_out = '0; gpio_oe = '0;
    #1;
    chk(tag, 64'(pin_out), (p < 0) ? 64'd0 : (64'd1 << p));
    chk(tag, 64'(pin_oe),  (p < 0) ? 64'd0 : (64'd1 << p));
  endtask

  task automatic load(bit en, logic [NR-1:0] r, logic [NP-1:0] sk);
    @(negedge clk);
    xbar_en = en; res_en = r; skip = sk;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    gpio_out = 16'hA5C3; gpio_oe = 16'h0F0F; pin_in = '0;
    #1;
    chk("R11 pin_out", 64'(pin_out), 64'hA5C3);
    chk("R11 sig_in", 64'(sig_in), 64'h1FFF);
    chk("R11 overflow", 64'(overflow), 0);
    rst_ni = 1'b1;

    // config B: UART + SPI, skip pins 0 and 2
    load(1, 7'b0000101, 16'h0005);
    route("R1 uart_tx", 0, 4);
    route("R1 uart_rx", 1, 5);
    route("R3 spi_sck", 4, 1);
    route("R3 spi_miso", 5, 3);
    route("R3 spi_mosi", 6, 6);
    route("R3 spi_nss", 7, 7);
    route("R12 can off", 2, -1);
    route("R12 i2c off", 8, -1);
    sig_out = '0; gpio_out = 16'h8005; gpio_oe = 16'h8001; #1;
    chk("R7 gpio out", 64'(pin_out & 16'h8005), 64'h8005);
    chk("R4 skipped oe", 64'(pin_oe & 16'h8005), 64'h8001);

    // UART overrides skip
    load(1, 7'b0000001, 16'h0030);
    route("R1 skip override", 1, 5);

    // config C: UART CAN SPI I2C, skip 0 and 2
    load(1, 7'b0001111, 16'h0005);
    route("R2 can_tx", 2, 6);
    route("R2 can_rx", 3, 7);
    route("R5 spi_sck", 4, 1);
    route("R5 spi_mosi", 6, 8);
    route("R5 i2c_sda", 8, 10);
    route("R5 i2c_scl", 9, 11);
    chk("R6 no overflow", 64'(overflow), 0);

    // R9: new config sampled only at the edge
    @(negedge clk);
    sig_out = NS'(1) << 4; sig_oe = NS'(1) << 4;
    res_en = 7'b0001101; skip = 16'hFFF0;
    #1;
    chk("R9 old map", 64'(pin_out), 64'h0002);
    @(negedge clk); #1;
    chk("R9 new map", 64'(pin_out), 64'h0001);
    // config D now active: overflow
    route("R6 i2c unplaced", 8, -1);
    chk("R6 overflow", 64'(overflow), 1);
    pin_in = '0; #1;
    chk("R10 idle i2c", 64'(sig_in[8]), 1);
    chk("R10 miso pin1", 64'(sig_in[5]), 0);
    chk("R10 uart rx pin5", 64'(sig_in[1]), 0);
    pin_in = 16'h0002; #1;
    chk("R10 miso follows", 64'(sig_in[5]), 1);

    // PWM only
    load(1, 7'b1110000, 16'h0000);
    route("R3 pwm0", 10, 0);
    route("R3 pwm2", 12, 2);
    load(0, 7'b1110000, 16'h0000);
    gpio_out = 16'h1234; pin_in = '0; #1;
    chk("R8 off pins", 64'(pin_out), 64'h1234);
    chk("R8 off sig_in", 64'(sig_in), 64'h1FFF);

    // random phase against reference model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i % 6 == 0) begin
        xbar_en = ($urandom_range(0, 7) != 0);
        res_en = NR'($urandom);
        skip = NP'($urandom) & NP'($urandom);
      end
      gpio_out = NP'($urandom); gpio_oe = NP'($urandom);
      pin_in = NP'($urandom); sig_out = NS'($urandom); sig_oe = NS'($urandom);
      #1;
      cmp_model("R3 model");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule